// File: doc/BRIEF.md
# Registered Bus Transceiver With Selectable Pipeline

This block joins two 18-bit buses, side A and side B. Traffic from A toward B is not registered: when the A-to-B enable is high, the B output follows the A input within the same cycle. Traffic from B toward A is clocked into a short shift chain of four registers. The path select input chooses whether side A is fed from the first register or the last one. The chain advances only on rising clock edges at which the active-low clock enable is low. Each direction has its own output enable, and each side reports its pad enable so that a surrounding pad ring can drive the real three-state buffers.

Each side has a keeper. At each rising edge where a side is being driven, its keeper captures the value on that side. While the side is not driven, its data output shows the captured value rather than an undefined level. All bit channels share the same controls, so the block acts as eighteen identical slices.

Top module: `regbus_xcvr`

## Requirements
- R1: While `en_ab` is 1, `b_oe` is 1 and `b_out` equals `a_in` in the same cycle, on every bit.
- R2: `a_oe` equals `en_ba` at all times. While `en_ba` is 1, `a_out` shows the register chosen by `path_sel`: 0 means the first register and 1 means the fourth.
- R3: With `path_sel` = 0, a `b_in` word taken at an enabled rising edge appears on `a_out` right after that edge, one cycle after capture.
- R4: With `path_sel` = 1, a captured `b_in` word appears on `a_out` after the fourth enabled rising edge, counting the capture edge. Edges with `clk_en_n` = 1 do not count.
- R5: At a rising edge where `clk_en_n` is 1, no register of the B-to-A chain changes. Under a stable `path_sel` and `en_ba`, `a_out` stays the same.
- R6: A change of `path_sel` moves `a_out` at once to the other register's present contents. Nothing is flushed or cleared.
- R7: While `en_ab` is 0, `b_oe` is 0 and `b_out` holds the `a_in` value sampled at the last rising edge where `en_ab` was 1. Changes on `a_in` have no effect on it.
- R8: While `en_ba` is 0, `a_oe` is 0 and `a_out` holds the value that `a_out` carried just before the last rising edge where `en_ba` was 1.
- R9: A rising edge with `rst` = 1 clears all four chain registers and both keepers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Active-low enable for the B-to-A register chain |
| path_sel | input | 1 | 0 selects the single-register path, 1 selects the four-stage path |
| en_ab | input | 1 | Drive side B from side A, active high |
| en_ba | input | 1 | Drive side A from the register chain, active high |
| a_in | input | 18 | Word received on side A |
| a_out | output | 18 | Word presented on side A |
| a_oe | output | 1 | Pad enable for side A |
| b_in | input | 18 | Word received on side B |
| b_out | output | 18 | Word presented on side B |
| b_oe | output | 1 | Pad enable for side B |

## Verification
A lone token is pushed through the chain with zero words behind it and a stalled edge placed in the middle of the sequence. This measures the latency of both paths and shows that a stalled edge does not count toward the four. With the chain filled with known words, `path_sel` is toggled while the chain is frozen, which tells a plain re-tap apart from a flush. Long random runs mix enables, stalls and path changes, and a bench model checks every cycle against them. The model separates the keeper values from the live flow-through values and exposes any bit slice that behaves differently from its neighbours.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int unsigned DEF_WIDTH  = 18;
    localparam int unsigned DEF_STAGES = 4;

    typedef enum logic {
        PATH_SHORT = 1'b0,
        PATH_LONG  = 1'b1
    } path_e;
endpackage

// File: rtl/xcvr_pipe.sv
module xcvr_pipe
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  path_e            sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } pipe_s;

    pipe_s pipe_d, pipe_q;

    // next state: shift only on an enabled edge
    always_comb begin
        pipe_d = pipe_q;
        if (rst) begin
            pipe_d.stg = '0;
        end else if (!load_n) begin
            pipe_d.stg[0] = din;
            for (int i = 1; i < STAGES; i++) begin
                pipe_d.stg[i] = pipe_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    // output tap: first or last stage, no flush on a change
    generate
        if (STAGES == 1) begin : g_one
            assign dout = pipe_q.stg[0];
        end else begin : g_many
            assign dout = (sel == PATH_LONG) ? pipe_q.stg[LAST] : pipe_q.stg[0];
        end
    endgenerate
endmodule

// File: rtl/xcvr_keep.sv
module xcvr_keep #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drive,
    input  logic [WIDTH-1:0] live,
    output logic [WIDTH-1:0] pad,
    output logic             oe
);
    typedef struct packed {
        logic [WIDTH-1:0] held;
    } keep_s;

    keep_s keep_d, keep_q;

    always_comb begin
        keep_d = keep_q;
        if (rst) begin
            keep_d.held = '0;
        end else if (drive) begin
            keep_d.held = live;
        end
    end

    always_ff @(posedge clk) begin
        keep_q <= keep_d;
    end

    assign pad = drive ? live : keep_q.held;
    assign oe  = drive;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en_n,
    input  logic             path_sel,
    input  logic             en_ab,
    input  logic             en_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    path_e            sel_e;
    logic [WIDTH-1:0] tap_w;

    assign sel_e = path_e'(path_sel);

    // B toward A: clocked chain
    xcvr_pipe #(.WIDTH(WIDTH), .STAGES(STAGES)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .load_n (clk_en_n),
        .sel    (sel_e),
        .din    (b_in),
        .dout   (tap_w)
    );

    // side A keeper, fed from the chain tap
    xcvr_keep #(.WIDTH(WIDTH)) u_keep_a (
        .clk   (clk),
        .rst   (rst),
        .drive (en_ba),
        .live  (tap_w),
        .pad   (a_out),
        .oe    (a_oe)
    );

    // side B keeper, fed straight from side A
    xcvr_keep #(.WIDTH(WIDTH)) u_keep_b (
        .clk   (clk),
        .rst   (rst),
        .drive (en_ab),
        .live  (a_in),
        .pad   (b_out),
        .oe    (b_oe)
    );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_en_n,
    input logic             path_sel,
    input logic             en_ab,
    input logic             en_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    // R1
    flow_ab_chk: assert property (@(posedge clk) disable iff (rst)
        en_ab |-> (b_oe && b_out == a_in));

    // R7
    keep_b_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        (!en_ab && $past(!en_ab)) |-> (!b_oe && $stable(b_out)));

    // R5
    stall_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
        ($past(clk_en_n) && $stable(path_sel) && en_ba && $past(en_ba)) |-> $stable(a_out));

    // R3
    short_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !path_sel) |=> (path_sel || !en_ba || a_out == $past(b_in)));

    // R9
    reset_a_chk: assert property (@(posedge clk)
        rst |=> (a_out == '0));

    // R9
    reset_b_chk: assert property (@(posedge clk)
        rst |=> (en_ab || b_out == '0));
endmodule

bind regbus_xcvr xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en_n (clk_en_n),
    .path_sel (path_sel),
    .en_ab    (en_ab),
    .en_ba    (en_ba),
    .a_in     (a_in),
    .a_out    (a_out),
    .b_in     (b_in),
    .b_out    (b_out),
    .b_oe     (b_oe)
);

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst, clk_en_n, path_sel, en_ab, en_ba;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model state
    logic [W-1:0] m_stg [4];
    logic [W-1:0] m_ha, m_hb;

    always #10 clk = ~clk;

    regbus_xcvr u_dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .path_sel(path_sel),
        .en_ab(en_ab), .en_ba(en_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] m_tap();
        return path_sel ? m_stg[3] : m_stg[0];
    endfunction

    function automatic logic [W-1:0] m_a();
        return en_ba ? m_tap() : m_ha;
    endfunction

    function automatic logic [W-1:0] m_b();
        return en_ab ? a_in : m_hb;
    endfunction

    // check settled outputs, take one edge, update model, return at negedge
    task automatic step();
        #2;
        chk(!en_ba ? "R8" : (path_sel ? "R4" : "R3"), a_out, m_a());
        chk(en_ab ? "R1" : "R7", b_out, m_b());
        chk("R2", {17'd0, a_oe}, {17'd0, en_ba});
        chk(en_ab ? "R1" : "R7", {17'd0, b_oe}, {17'd0, en_ab});
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 4; i++) m_stg[i] = '0;
            m_ha = '0;
            m_hb = '0;
        end else begin
            if (en_ba) m_ha = m_tap();
            if (en_ab) m_hb = a_in;
            if (!clk_en_n) begin
                for (int i = 3; i > 0; i--) m_stg[i] = m_stg[i-1];
                m_stg[0] = b_in;
            end
        end
        @(negedge clk);
    endtask

    task automatic look_a(input string req, input logic [W-1:0] exp);
        #2;
        chk(req, a_out, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_stg[i] = 'x;
        m_ha = 'x; m_hb = 'x;
        rst = 1; clk_en_n = 0; path_sel = 0; en_ab = 0; en_ba = 0;
        a_in = '0; b_in = '0;
        @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < 4; i++) m_stg[i] = '0;
        m_ha = '0; m_hb = '0;
        @(negedge clk);
        // R9: reset state
        look_a("R9", '0);
        chk("R9", b_out, '0);
        en_ba = 1;
        path_sel = 1;
        look_a("R9", '0);
        rst = 0;

        // R3: single path latency
        path_sel = 0; b_in = 18'h2A5C3;
        step();
        look_a("R3", 18'h2A5C3);

        // R9: reset mid-run clears the chain
        rst = 1; step(); rst = 0;
        path_sel = 1; look_a("R9", '0);

        // R4: token through four enabled edges with a stall in the middle
        b_in = 18'h3F00F; step();
        look_a("R4", '0);
        b_in = '0; clk_en_n = 1; step();
        look_a("R5", '0);
        clk_en_n = 0; step();
        look_a("R4", '0);
        step();
        look_a("R4", '0);
        step();
        look_a("R4", 18'h3F00F);

        // R6: fill with known words, freeze, toggle the tap
        b_in = 18'h11111; step();
        b_in = 18'h22222; step();
        b_in = 18'h33333; step();
        b_in = 18'h04444; step();
        clk_en_n = 1;
        b_in = 18'h15555;
        look_a("R6", 18'h11111);
        path_sel = 0; look_a("R6", 18'h04444);
        path_sel = 1; look_a("R6", 18'h11111);
        // R5: stalled edges change nothing
        step(); look_a("R5", 18'h11111);
        step(); path_sel = 0; look_a("R5", 18'h04444);

        // R8: disable side A, chain moves, output held
        path_sel = 0; step();
        en_ba = 0; clk_en_n = 0; b_in = 18'h0BEEF; step();
        look_a("R8", 18'h04444);
        b_in = 18'h1CAFE; step();
        look_a("R8", 18'h04444);
        en_ba = 1; look_a("R2", 18'h1CAFE);

        // R1 / R7: flow-through then hold on side B
        en_ab = 1; a_in = 18'h2D00D; #2; chk("R1", b_out, 18'h2D00D);
        step();
        en_ab = 0; a_in = 18'h0F0F0; #2; chk("R7", b_out, 18'h2D00D);
        a_in = 18'h3FFFF; step(); #2; chk("R7", b_out, 18'h2D00D);

        // constrained random, model-checked every cycle
        for (int n = 0; n < 3000; n++) begin
            a_in     = W'($urandom);
            b_in     = W'($urandom);
            en_ab    = ($urandom % 8) != 0;
            en_ba    = ($urandom % 8) != 0;
            clk_en_n = ($urandom % 4) == 0;
            if ($urandom % 16 == 0) path_sel = ~path_sel;
            rst      = ($urandom % 500) == 0;
            step();
        end
        rst = 0;
        finish_run();
    end
endmodule